// File: doc/BRIEF.md
# Branch on Memory Bit Unit

This unit carries out the sixteen conditional branches that test a single bit of a zero-page byte. An 8-bit core hands it an opcode and the address at which that opcode sits. The unit then makes three reads through a byte-wide synchronous memory port. The first two fetch the operand address byte and the signed displacement byte. The third reads the zero-page location that the address byte names.

The unit picks one bit of the operand byte. Both the bit and the sense of the test come from the opcode. If the test passes, the unit produces the branch target. If it fails, it produces the address of the next instruction. With the result it reports the instruction's architectural cycle count and a one-cycle completion strobe.

The core keeps ownership of the status flags, which this unit never touches. It also keeps opcode fetch and everything else outside this one instruction family.

Top module: `bitbr_unit`

## Requirements
- R1: Opcode bits [6:4] select the tested bit (0..7) and opcode bit 7 selects the sense. A value of 0 branches when the bit is clear and 1 branches when it is set. The low nibble is always 0xF.
- R2: After a start is accepted, `mem_rd` is high for exactly three consecutive cycles. The read addresses are `pc_in+1` (address byte), then `pc_in+2` (displacement byte), then `{8'h00, zp}`. Read data is valid on `mem_rdata` in the cycle after its request.
- R3: When the test passes, `pc_out` equals `pc_in + 3 + sign_extend(disp)`, modulo 2^16.
- R4: When the test fails, `pc_out` equals `pc_in + 3` and `cycles` equals 5.
- R5: A passing test reports `cycles` = 7 when the target's upper address byte differs from that of `pc_in + 3`, and 5 otherwise.
- R6: `done` is a single-cycle pulse. It is sampled high on the fifth falling edge after the falling edge where `start` was raised. `pc_out`, `cycles` and `taken` hold their values until the next result.
- R7: A `start` that arrives while an instruction is in progress is ignored and produces no extra result.
- R8: While reset is held and after it is released, `done`, `mem_rd`, `taken`, `pc_out` and `cycles` read zero until the first result.
- R9: `taken` is 1 together with `done` exactly when the branch is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin one instruction (sampled only when idle) |
| opcode | input | 8 | Bit-branch opcode |
| pc_in | input | 16 | Address of the opcode byte |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Read data, one cycle after the request |
| done | output | 1 | Result valid strobe |
| taken | output | 1 | Branch was taken |
| pc_out | output | 16 | Next program counter |
| cycles | output | 4 | Architectural cycle count of the instruction |

## Verification
The bench runs all sixteen opcodes with the tested bit at both values. The other bits of the operand always hold the opposite value, so a design that decodes the wrong bit index or inverts the sense gives the wrong `taken` and `pc_out`. The displacements cover forward, backward, maximum positive (0x7F) and most negative (0x80) values. Some branches cross a page forward and some backward. One case has the fall-through address itself on a new page while the branch does not leave it. A design that measures the page change from the opcode address instead of the next instruction would report 7 cycles there. The read address sequence is logged, which catches a swapped fetch order or a zero-page read that leaks the upper byte. A second start during a busy instruction must not produce a second result.

// File: rtl/bitbr_pkg.sv
package bitbr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_DISP = 3'd2,
    ST_OPER = 3'd3,
    ST_EVAL = 3'd4
  } bitbr_state_e;

  localparam int CYC_BASE     = 5;
  localparam int CYC_PAGE_PEN = 2;
  localparam int INSN_LEN     = 3;
endpackage

// File: rtl/bitbr_rst_sync.sv
module bitbr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/bitbr_decode.sv
module bitbr_decode #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] opcode,
  input  logic [DATA_W-1:0] operand,
  output logic              hit
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam int IDX_LSB = 4;

  logic [IDX_W-1:0] bit_idx;
  logic             want_set;

  always_comb begin
    bit_idx  = opcode[IDX_LSB +: IDX_W];
    want_set = opcode[DATA_W-1];
    hit      = (operand[bit_idx] == want_set);
  end
endmodule

// File: rtl/bitbr_target.sv
module bitbr_target #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] pc_base,
  input  logic [DATA_W-1:0] disp,
  output logic [ADDR_W-1:0] fall_pc,
  output logic [ADDR_W-1:0] tgt_pc,
  output logic              page_cross
);
  import bitbr_pkg::*;
  localparam int EXT_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] disp_ext;

  always_comb begin
    disp_ext   = {{EXT_W{disp[DATA_W-1]}}, disp};
    fall_pc    = pc_base + ADDR_W'(INSN_LEN);
    tgt_pc     = fall_pc + disp_ext;
    page_cross = (tgt_pc[ADDR_W-1:DATA_W] != fall_pc[ADDR_W-1:DATA_W]);
  end
endmodule

// File: rtl/bitbr_unit.sv
module bitbr_unit #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] opcode,
  input  logic [ADDR_W-1:0] pc_in,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              taken,
  output logic [ADDR_W-1:0] pc_out,
  output logic [CNT_W-1:0]  cycles
);
  import bitbr_pkg::*;
  localparam int EXT_W = ADDR_W - DATA_W;
  localparam logic [CNT_W-1:0] CNT_BASE  = CNT_W'(CYC_BASE);
  localparam logic [CNT_W-1:0] CNT_CROSS = CNT_W'(CYC_BASE + CYC_PAGE_PEN);

  logic rst_sync_n;

  bitbr_state_e      state_q, state_d;
  logic [DATA_W-1:0] opc_q, zp_q, disp_q;
  logic [ADDR_W-1:0] pc_q, pc_out_q, pc_out_d;
  logic [CNT_W-1:0]  cyc_q, cyc_d;
  logic              taken_q, taken_d, done_q, done_d;
  logic              ld_start, ld_zp, ld_disp, ld_res;
  logic              hit, page_cross;
  logic [ADDR_W-1:0] fall_pc, tgt_pc;

  bitbr_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bitbr_decode #(.DATA_W(DATA_W)) u_decode (
    .opcode  (opc_q),
    .operand (mem_rdata),
    .hit     (hit)
  );

  bitbr_target #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_target (
    .pc_base    (pc_q),
    .disp       (disp_q),
    .fall_pc    (fall_pc),
    .tgt_pc     (tgt_pc),
    .page_cross (page_cross)
  );

  // next-state and datapath control
  always_comb begin
    state_d  = state_q;
    ld_start = 1'b0;
    ld_zp    = 1'b0;
    ld_disp  = 1'b0;
    ld_res   = 1'b0;
    mem_rd   = 1'b0;
    mem_addr = '0;
    done_d   = 1'b0;
    pc_out_d = pc_out_q;
    cyc_d    = cyc_q;
    taken_d  = taken_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          ld_start = 1'b1;
          state_d  = ST_ADDR;
        end
      end
      ST_ADDR: begin
        mem_rd   = 1'b1;
        mem_addr = pc_q + ADDR_W'(1);
        state_d  = ST_DISP;
      end
      ST_DISP: begin
        mem_rd   = 1'b1;
        mem_addr = pc_q + ADDR_W'(2);
        ld_zp    = 1'b1;
        state_d  = ST_OPER;
      end
      ST_OPER: begin
        mem_rd   = 1'b1;
        mem_addr = {{EXT_W{1'b0}}, zp_q};
        ld_disp  = 1'b1;
        state_d  = ST_EVAL;
      end
      ST_EVAL: begin
        ld_res   = 1'b1;
        done_d   = 1'b1;
        taken_d  = hit;
        pc_out_d = hit ? tgt_pc : fall_pc;
        cyc_d    = (hit && page_cross) ? CNT_CROSS : CNT_BASE;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      opc_q <= '0;
      pc_q  <= '0;
    end else if (ld_start) begin
      opc_q <= opcode;
      pc_q  <= pc_in;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      zp_q <= '0;
    end else if (ld_zp) begin
      zp_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      disp_q <= '0;
    end else if (ld_disp) begin
      disp_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_out_q <= '0;
      cyc_q    <= '0;
      taken_q  <= 1'b0;
    end else if (ld_res) begin
      pc_out_q <= pc_out_d;
      cyc_q    <= cyc_d;
      taken_q  <= taken_d;
    end
  end

  assign done   = done_q;
  assign taken  = taken_q;
  assign pc_out = pc_out_q;
  assign cycles = cyc_q;

  // R6: completion strobe lasts one cycle
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_q |=> !done_q);

  // R5: only the two legal counts are reported
  assert_cyc_legal_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_q |-> (cyc_q == CNT_BASE || cyc_q == CNT_CROSS));

  // R4: a failed test costs the base count and falls through
  assert_fall_cyc_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_q && !taken_q) |-> (cyc_q == CNT_BASE));

  assert_fall_pc_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_q && !taken_q) |-> (pc_out_q == pc_q + ADDR_W'(INSN_LEN)));

  // R7: the captured instruction cannot change while busy
  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q != ST_IDLE) |=> ($stable(opc_q) && $stable(pc_q)));

  // R2: the operand read stays in page zero
  assert_zp_page_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_rd && state_q == ST_OPER) |-> (mem_addr[ADDR_W-1:DATA_W] == '0));
endmodule

// File: tb/bitbr_unit_bench.sv
module bitbr_unit_bench;
  typedef struct {
    logic [15:0] pc;
    logic [3:0]  cyc;
    logic        tk;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [7:0]  opcode;
  logic [15:0] pc_in;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        done, taken;
  logic [15:0] pc_out;
  logic [3:0]  cycles;

  int checks = 0;
  int bad = 0;
  int cyc_cnt = 0;

  logic [7:0]  mem [logic [15:0]];
  logic [15:0] rd_log [$];
  exp_t        exp_q [$];

  always #4 clk = ~clk;

  bitbr_unit u_bitbr_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .pc_in(pc_in),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .done(done), .taken(taken), .pc_out(pc_out), .cycles(cycles)
  );

  // synchronous memory model
  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 8'hA5;
      rd_log.push_back(mem_addr);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // monitor: pop scoreboard on each result
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7", "unexpected result", pc_out, 16'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(taken == e.tk, "R9", "taken", {15'b0, taken}, {15'b0, e.tk});
        chk(pc_out == e.pc, e.tk ? "R3" : "R4", "pc_out", pc_out, e.pc);
        chk(cycles == e.cyc, e.tk ? "R5" : "R4", "cycles", {12'b0, cycles}, {12'b0, e.cyc});
      end
    end
  end

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt == 150000) begin
      bad++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cyc_cnt);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  task automatic run_case(input logic [7:0] op, input logic [7:0] operand,
                          input logic [7:0] zp, input logic [7:0] disp,
                          input logic [15:0] pc, input bit restart);
    exp_t e;
    logic [15:0] fall, tgt;
    bit tk;
    int lat;
    mem.delete();
    mem[pc + 16'd1] = zp;
    mem[pc + 16'd2] = disp;
    mem[{8'h00, zp}] = operand;
    rd_log.delete();
    // R1: bit = op[6:4], sense = op[7]
    tk   = (operand[op[6:4]] == op[7]);
    fall = pc + 16'd3;
    tgt  = fall + {{8{disp[7]}}, disp};
    e.tk  = tk;
    e.pc  = tk ? tgt : fall;
    e.cyc = (tk && (tgt[15:8] != fall[15:8])) ? 4'd7 : 4'd5;
    exp_q.push_back(e);
    @(negedge clk);
    start = 1'b1; opcode = op; pc_in = pc;
    @(negedge clk);
    lat = 1;
    if (restart) begin
      opcode = op ^ 8'h80; pc_in = pc + 16'h0040;   // R7: ignored
    end else begin
      start = 1'b0;
    end
    @(negedge clk);
    start = 1'b0; lat = 2;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == 5, "R6", "latency", 16'(lat), 16'd5);
    chk(rd_log.size() == 3, "R2", "read count", 16'(rd_log.size()), 16'd3);
    if (rd_log.size() == 3) begin
      chk(rd_log[0] == pc + 16'd1, "R2", "read0", rd_log[0], pc + 16'd1);
      chk(rd_log[1] == pc + 16'd2, "R2", "read1", rd_log[1], pc + 16'd2);
      chk(rd_log[2] == {8'h00, zp}, "R2", "read2", rd_log[2], {8'h00, zp});
    end
    @(negedge clk);
    chk(!done, "R6", "done width", {15'b0, done}, 16'd0);
    chk(pc_out == e.pc, "R6", "pc hold", pc_out, e.pc);
    if (restart) begin
      repeat (8) @(negedge clk);
      chk(exp_q.size() == 0 && !done, "R7", "no second result",
          16'(exp_q.size()), 16'd0);
    end
  endtask

  initial begin
    logic [7:0] dtab [4];
    dtab[0] = 8'h10; dtab[1] = 8'hF0; dtab[2] = 8'h7F; dtab[3] = 8'h80;
    rst_n = 1'b0; start = 1'b0; opcode = 8'h0F; pc_in = 16'h0;
    repeat (3) @(negedge clk);
    chk(!done && !mem_rd && pc_out == 16'h0, "R8", "in reset", pc_out, 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!done && !mem_rd && !taken && cycles == 4'd0 && pc_out == 16'h0,
        "R8", "after release", {12'b0, cycles}, 16'h0);
    // R1 R3 R4 R5 R9: every opcode, both bit values
    for (int i = 0; i < 16; i++) begin
      for (int v = 0; v < 2; v++) begin
        logic [7:0] op, msk, oper;
        op   = {i[3:0], 4'hF};
        msk  = 8'h01 << i[2:0];
        oper = (v == 1) ? msk : ~msk;
        run_case(op, oper, 8'h30 + 8'(i), dtab[(i * 2 + v) % 4],
                 16'h20C0 + 16'(i) * 16'h0101, 1'b0);
      end
    end
    // R5: backward page cross, taken on bit 3 set
    run_case(8'hBF, 8'h08, 8'h12, 8'hF0, 16'h3001, 1'b0);
    // R5: fall-through on a new page, zero displacement, no penalty
    run_case(8'h2F, 8'hFB, 8'h13, 8'h00, 16'h40FE, 1'b0);
    // R3: wrap at top of address space
    run_case(8'hFF, 8'h80, 8'h14, 8'h05, 16'hFFFC, 1'b0);
    // R7: start repeated while busy
    run_case(8'h5F, 8'h00, 8'h15, 8'h20, 16'h5010, 1'b1);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R6", "scoreboard drained", 16'(exp_q.size()), 16'd0);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule